// File: doc/BRIEF.md
# Root Clock Generator Configuration Commit Block

This block holds the programming state of a root clock generator. Software writes a source choice, a pre-divider value, a counter mode and three counter values (M, N and D) over a simple word-addressed bus. Those writes land in shadow registers only. The values that drive the divider datapaths live in a separate set of active registers, and they do not change until software asks for an update.

An update request is a 1 written to bit 0 of the command word. The block waits for a cycle in which the generated clock is reported low. On that edge it copies every shadow field into the active set, clears all per-register dirty flags and drops the request bit. Software polls the request bit to see that the hand-off has finished. The root enable follows the same rule and changes only on a low-clock cycle. The resulting gate state can be read back as a read-only root-off flag.

The active source code drives a one-hot select for a small input mux. When the source changes, the select first drops to all-zero for one cycle and only then raises the new line, so two inputs are never selected together.

Top module: `clkroot_cfg_commit`

## Requirements
- R1: After reset the root gate is off, `root_off` is 1, the command word reads 0x8000_0000 (update clear, enable clear, no dirty flags), every active field is 0 and `src_sel_oh` selects input 0 (value 1).
- R2: Word offsets decode as command 0x0, configuration 0x4, M 0x8, N 0xC and D 0x10. The configuration word keeps the pre-divider in bits [PDIV_W-1:0], the source code in bits [10:8] and the mode in bits [13:12]. M, N and D keep their low MND_W bits. All other bits read 0. Reads and writes at any other address or with a nonzero byte offset read 0 and change nothing.
- R3: Any write to a register sets its dirty flag in the command word: configuration in bit 4, N in bit 5, M in bit 6, D in bit 7. All dirty flags clear when an update commits.
- R4: A write with command bit 0 set raises the update request, which reads back as 1 in bit 0. Writing 0 to bit 0 does not withdraw a pending request.
- R5: Active fields take their shadow values only on a clock edge where `root_clk_low` is 1 and an update is pending. At any other edge they hold.
- R6: If software writes a register in the commit cycle, that register's shadow takes the new value and the active copy takes the old one, and its dirty flag stays set. A command write that requests an update in the commit cycle leaves the request pending.
- R7: Command bit 1 is the shadow root enable. `root_gate_en` takes it at each edge with `root_clk_low` high. Command bit 31 reads as `root_off` (1 while the gate is off), and bus writes to bit 31 have no effect.
- R8: Shadow writes with no update request never change the active fields.
- R9: `src_sel_oh` has at most one bit set. A change of source passes through all-zero for exactly one cycle before the new line rises. Source codes at or above NUM_SRC select nothing.
- R10: A pending update completes, and the request bit reads 0, at the first edge where `root_clk_low` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| root_clk_low | input | 1 | High while the generated clock is in its low phase (safe point) |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | ADDR_W | Byte address of the word accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| root_gate_en | output | 1 | Root clock gate enable |
| root_off | output | 1 | 1 while the root gate is off |
| act_prediv | output | PDIV_W | Active pre-divider value |
| act_src | output | 3 | Active source code |
| act_mode | output | 2 | Active counter mode |
| act_m | output | MND_W | Active M value |
| act_n | output | MND_W | Active N value |
| act_d | output | MND_W | Active D value |
| src_sel_oh | output | NUM_SRC | One-hot input mux select |

## Verification
Read data is combinational, so a value written at one edge can be read back before the next edge. Shadow contents, dirty flags and the request bit change at the edge that takes the write. The active fields, the cleared flags and the gate enable change at the first edge that samples `root_clk_low` high. The select goes to zero one edge after the active source changes and reaches its new value one edge after that. The bench drives every input just after a falling edge and samples just after the next falling edge, so each check lands in the half-cycle after the edge at which its result is due. The sweep walks all eight source codes, which covers valid-to-valid, valid-to-invalid and invalid-to-invalid select transitions.

// File: rtl/clkroot_pkg.sv
package clkroot_pkg;
  // word indices (byte offset >> 2)
  localparam int unsigned WORD_CMD = 0;
  localparam int unsigned WORD_CFG = 1;
  localparam int unsigned WORD_M   = 2;
  localparam int unsigned WORD_N   = 3;
  localparam int unsigned WORD_D   = 4;

  // command word fields
  localparam int unsigned CMD_UPD_BIT    = 0;
  localparam int unsigned CMD_ROOTEN_BIT = 1;
  localparam int unsigned CMD_DIRTY_LSB  = 4;
  localparam int unsigned CMD_OFF_BIT    = 31;

  // configuration word fields
  localparam int unsigned SRC_W        = 3;
  localparam int unsigned MODE_W       = 2;
  localparam int unsigned CFG_SRC_LSB  = 8;
  localparam int unsigned CFG_MODE_LSB = 12;

  // dirty vector positions (command bits CMD_DIRTY_LSB + idx)
  localparam int unsigned DIRTY_CFG = 0;
  localparam int unsigned DIRTY_N   = 1;
  localparam int unsigned DIRTY_M   = 2;
  localparam int unsigned DIRTY_D   = 3;
  localparam int unsigned DIRTY_W   = 4;

  localparam int unsigned DATA_W = 32;
endpackage

// File: rtl/clkroot_shadow_regs.sv
module clkroot_shadow_regs
  import clkroot_pkg::*;
#(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned PDIV_W = 5,
  parameter int unsigned MND_W  = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_we,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  input  logic                commit,
  input  logic                root_off,
  output logic [PDIV_W-1:0]   sh_prediv,
  output logic [SRC_W-1:0]    sh_src,
  output logic [MODE_W-1:0]   sh_mode,
  output logic [MND_W-1:0]    sh_m,
  output logic [MND_W-1:0]    sh_n,
  output logic [MND_W-1:0]    sh_d,
  output logic                sh_root_en,
  output logic                upd_pend
);
  localparam int unsigned IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0]   word_idx;
  logic               aligned;
  logic               hit_cmd, hit_cfg, hit_m, hit_n, hit_d;
  logic               wr_cmd, wr_cfg, wr_m, wr_n, wr_d;

  logic [PDIV_W-1:0]  prediv_q;
  logic [SRC_W-1:0]   src_q;
  logic [MODE_W-1:0]  mode_q;
  logic [MND_W-1:0]   m_q, n_q, d_q;
  logic               root_en_q;
  logic               pend_q, pend_d;
  logic [DIRTY_W-1:0] dirty_q, dirty_d;

  // address decode
  assign word_idx = bus_addr[ADDR_W-1:2];
  assign aligned  = (bus_addr[1:0] == 2'b00);
  assign hit_cmd  = aligned && (word_idx == IDX_W'(WORD_CMD));
  assign hit_cfg  = aligned && (word_idx == IDX_W'(WORD_CFG));
  assign hit_m    = aligned && (word_idx == IDX_W'(WORD_M));
  assign hit_n    = aligned && (word_idx == IDX_W'(WORD_N));
  assign hit_d    = aligned && (word_idx == IDX_W'(WORD_D));

  assign wr_cmd = bus_we && hit_cmd;
  assign wr_cfg = bus_we && hit_cfg;
  assign wr_m   = bus_we && hit_m;
  assign wr_n   = bus_we && hit_n;
  assign wr_d   = bus_we && hit_d;

  // next state: a write in the commit cycle wins over the clear
  always_comb begin
    dirty_d = commit ? '0 : dirty_q;
    if (wr_cfg) dirty_d[DIRTY_CFG] = 1'b1;
    if (wr_n)   dirty_d[DIRTY_N]   = 1'b1;
    if (wr_m)   dirty_d[DIRTY_M]   = 1'b1;
    if (wr_d)   dirty_d[DIRTY_D]   = 1'b1;
    pend_d = (pend_q && !commit) || (wr_cmd && bus_wdata[CMD_UPD_BIT]);
  end

  // status registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      dirty_q <= '0;
    end else begin
      pend_q  <= pend_d;
      dirty_q <= dirty_d;
    end
  end

  // shadow storage, each with its own write enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      root_en_q <= 1'b0;
      prediv_q  <= '0;
      src_q     <= '0;
      mode_q    <= '0;
      m_q       <= '0;
      n_q       <= '0;
      d_q       <= '0;
    end else begin
      if (wr_cmd) root_en_q <= bus_wdata[CMD_ROOTEN_BIT];
      if (wr_cfg) begin
        prediv_q <= bus_wdata[PDIV_W-1:0];
        src_q    <= bus_wdata[CFG_SRC_LSB +: SRC_W];
        mode_q   <= bus_wdata[CFG_MODE_LSB +: MODE_W];
      end
      if (wr_m) m_q <= bus_wdata[MND_W-1:0];
      if (wr_n) n_q <= bus_wdata[MND_W-1:0];
      if (wr_d) d_q <= bus_wdata[MND_W-1:0];
    end
  end

  // readback
  always_comb begin
    bus_rdata = '0;
    if (hit_cmd) begin
      bus_rdata[CMD_UPD_BIT]              = pend_q;
      bus_rdata[CMD_ROOTEN_BIT]           = root_en_q;
      bus_rdata[CMD_DIRTY_LSB +: DIRTY_W] = dirty_q;
      bus_rdata[CMD_OFF_BIT]              = root_off;
    end else if (hit_cfg) begin
      bus_rdata[PDIV_W-1:0]              = prediv_q;
      bus_rdata[CFG_SRC_LSB +: SRC_W]    = src_q;
      bus_rdata[CFG_MODE_LSB +: MODE_W]  = mode_q;
    end else if (hit_m) begin
      bus_rdata[MND_W-1:0] = m_q;
    end else if (hit_n) begin
      bus_rdata[MND_W-1:0] = n_q;
    end else if (hit_d) begin
      bus_rdata[MND_W-1:0] = d_q;
    end
  end

  assign sh_prediv  = prediv_q;
  assign sh_src     = src_q;
  assign sh_mode    = mode_q;
  assign sh_m       = m_q;
  assign sh_n       = n_q;
  assign sh_d       = d_q;
  assign sh_root_en = root_en_q;
  assign upd_pend   = pend_q;
endmodule

// File: rtl/clkroot_commit.sv
module clkroot_commit
  import clkroot_pkg::*;
#(
  parameter int unsigned PDIV_W = 5,
  parameter int unsigned MND_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              root_clk_low,
  input  logic              upd_pend,
  input  logic [PDIV_W-1:0] sh_prediv,
  input  logic [SRC_W-1:0]  sh_src,
  input  logic [MODE_W-1:0] sh_mode,
  input  logic [MND_W-1:0]  sh_m,
  input  logic [MND_W-1:0]  sh_n,
  input  logic [MND_W-1:0]  sh_d,
  input  logic              sh_root_en,
  output logic              commit,
  output logic [PDIV_W-1:0] act_prediv,
  output logic [SRC_W-1:0]  act_src,
  output logic [MODE_W-1:0] act_mode,
  output logic [MND_W-1:0]  act_m,
  output logic [MND_W-1:0]  act_n,
  output logic [MND_W-1:0]  act_d,
  output logic              root_gate_en
);
  logic gate_q, gate_d;

  // hand-off happens only while the generated clock is low
  assign commit = upd_pend && root_clk_low;

  always_comb begin
    gate_d = root_clk_low ? sh_root_en : gate_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gate_q <= 1'b0;
    else        gate_q <= gate_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_prediv <= '0;
      act_src    <= '0;
      act_mode   <= '0;
      act_m      <= '0;
      act_n      <= '0;
      act_d      <= '0;
    end else if (commit) begin
      act_prediv <= sh_prediv;
      act_src    <= sh_src;
      act_mode   <= sh_mode;
      act_m      <= sh_m;
      act_n      <= sh_n;
      act_d      <= sh_d;
    end
  end

  assign root_gate_en = gate_q;
endmodule

// File: rtl/clkroot_src_sel.sv
module clkroot_src_sel
  import clkroot_pkg::*;
#(
  parameter int unsigned NUM_SRC = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [SRC_W-1:0]   act_src,
  output logic [NUM_SRC-1:0] sel_oh
);
  localparam logic [NUM_SRC-1:0] RESET_SEL = NUM_SRC'(1);

  logic [NUM_SRC-1:0] target;
  logic [NUM_SRC-1:0] sel_q, sel_d;

  // decode; codes at or above NUM_SRC leave every line low
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_dec
    assign target[g] = (act_src == SRC_W'(g));
  end

  // break before make: drop the old line, then raise the new one
  always_comb begin
    sel_d = sel_q;
    if (sel_q != target) begin
      if (|sel_q) sel_d = '0;
      else        sel_d = target;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= RESET_SEL;
    else        sel_q <= sel_d;
  end

  assign sel_oh = sel_q;
endmodule

// File: rtl/clkroot_cfg_commit.sv
module clkroot_cfg_commit
  import clkroot_pkg::*;
#(
  parameter int unsigned ADDR_W  = 5,
  parameter int unsigned PDIV_W  = 5,
  parameter int unsigned MND_W   = 8,
  parameter int unsigned NUM_SRC = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               root_clk_low,
  input  logic               bus_we,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic               root_gate_en,
  output logic               root_off,
  output logic [PDIV_W-1:0]  act_prediv,
  output logic [2:0]         act_src,
  output logic [1:0]         act_mode,
  output logic [MND_W-1:0]   act_m,
  output logic [MND_W-1:0]   act_n,
  output logic [MND_W-1:0]   act_d,
  output logic [NUM_SRC-1:0] src_sel_oh
);
  logic              commit;
  logic              upd_pend;
  logic              sh_root_en;
  logic [PDIV_W-1:0] sh_prediv;
  logic [SRC_W-1:0]  sh_src;
  logic [MODE_W-1:0] sh_mode;
  logic [MND_W-1:0]  sh_m, sh_n, sh_d;

  assign root_off = !root_gate_en;

  clkroot_shadow_regs #(
    .ADDR_W(ADDR_W), .PDIV_W(PDIV_W), .MND_W(MND_W)
  ) i_shadow (
    .clk(clk), .rst_n(rst_n),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .commit(commit), .root_off(root_off),
    .sh_prediv(sh_prediv), .sh_src(sh_src), .sh_mode(sh_mode),
    .sh_m(sh_m), .sh_n(sh_n), .sh_d(sh_d),
    .sh_root_en(sh_root_en), .upd_pend(upd_pend)
  );

  clkroot_commit #(
    .PDIV_W(PDIV_W), .MND_W(MND_W)
  ) i_commit (
    .clk(clk), .rst_n(rst_n), .root_clk_low(root_clk_low),
    .upd_pend(upd_pend),
    .sh_prediv(sh_prediv), .sh_src(sh_src), .sh_mode(sh_mode),
    .sh_m(sh_m), .sh_n(sh_n), .sh_d(sh_d), .sh_root_en(sh_root_en),
    .commit(commit),
    .act_prediv(act_prediv), .act_src(act_src), .act_mode(act_mode),
    .act_m(act_m), .act_n(act_n), .act_d(act_d),
    .root_gate_en(root_gate_en)
  );

  clkroot_src_sel #(
    .NUM_SRC(NUM_SRC)
  ) i_src_sel (
    .clk(clk), .rst_n(rst_n), .act_src(act_src), .sel_oh(src_sel_oh)
  );
endmodule

// File: rtl/clkroot_cfg_commit_chk.sv
module clkroot_cfg_commit_chk #(
  parameter int unsigned ADDR_W  = 5,
  parameter int unsigned PDIV_W  = 5,
  parameter int unsigned MND_W   = 8,
  parameter int unsigned NUM_SRC = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic               root_clk_low,
  input logic               bus_we,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic [31:0]        bus_wdata,
  input logic               upd_pend,
  input logic               root_gate_en,
  input logic [PDIV_W-1:0]  act_prediv,
  input logic [2:0]         act_src,
  input logic [1:0]         act_mode,
  input logic [MND_W-1:0]   act_m,
  input logic [MND_W-1:0]   act_n,
  input logic [MND_W-1:0]   act_d,
  input logic [NUM_SRC-1:0] src_sel_oh
);
  logic req_wr;
  assign req_wr = bus_we && (bus_addr == '0) && bus_wdata[0];

  AST_SEL_ONEHOT0: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(src_sel_oh)); // R9

  AST_BREAK_BEFORE_MAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (|src_sel_oh) |=> ((src_sel_oh == $past(src_sel_oh)) || (src_sel_oh == '0))); // R9

  AST_ACT_HOLD_CLK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !root_clk_low |=> $stable({act_prediv, act_src, act_mode, act_m, act_n, act_d})); // R5

  AST_ACT_HOLD_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_pend |=> $stable({act_prediv, act_src, act_mode, act_m, act_n, act_d})); // R8

  AST_GATE_HOLD_CLK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !root_clk_low |=> $stable(root_gate_en)); // R7

  AST_UPD_DONE_ON_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_pend && root_clk_low && !req_wr) |=> !upd_pend); // R10
endmodule

bind clkroot_cfg_commit clkroot_cfg_commit_chk #(
  .ADDR_W(ADDR_W), .PDIV_W(PDIV_W), .MND_W(MND_W), .NUM_SRC(NUM_SRC)
) i_chk (
  .clk(clk), .rst_n(rst_n), .root_clk_low(root_clk_low),
  .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .upd_pend(upd_pend), .root_gate_en(root_gate_en),
  .act_prediv(act_prediv), .act_src(act_src), .act_mode(act_mode),
  .act_m(act_m), .act_n(act_n), .act_d(act_d), .src_sel_oh(src_sel_oh)
);

// File: tb/test_clkroot_cfg_commit.sv
module test_clkroot_cfg_commit;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 5, PDIV_W = 5, MND_W = 8, NUM_SRC = 6;
  localparam logic [4:0] A_CMD = 5'h00, A_CFG = 5'h04, A_M = 5'h08,
                         A_N = 5'h0C, A_D = 5'h10;

  logic clk = 1'b0;
  logic rst_n, root_clk_low, bus_we;
  logic [ADDR_W-1:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic root_gate_en, root_off;
  logic [PDIV_W-1:0] act_prediv;
  logic [2:0] act_src;
  logic [1:0] act_mode;
  logic [MND_W-1:0] act_m, act_n, act_d;
  logic [NUM_SRC-1:0] src_sel_oh;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  clkroot_cfg_commit #(.ADDR_W(ADDR_W), .PDIV_W(PDIV_W), .MND_W(MND_W), .NUM_SRC(NUM_SRC))
  i_clkroot_cfg_commit (
    .clk(clk), .rst_n(rst_n), .root_clk_low(root_clk_low),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .root_gate_en(root_gate_en), .root_off(root_off),
    .act_prediv(act_prediv), .act_src(act_src), .act_mode(act_mode),
    .act_m(act_m), .act_n(act_n), .act_d(act_d), .src_sel_oh(src_sel_oh)
  );

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    tick();
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  function automatic logic [NUM_SRC-1:0] oh(input int s);
    return (s < NUM_SRC) ? NUM_SRC'(1 << s) : '0;
  endfunction

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic [31:0] exp_cfg;
    int o_pd, o_src, o_md, o_m, o_n, o_d;
    rst_n = 1'b0; root_clk_low = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check("R1", "gate", 32'(root_gate_en), 0);
    check("R1", "root_off", 32'(root_off), 1);
    rd(A_CMD, r); check("R1", "cmd word", r, 32'h8000_0000);
    check("R1", "active", {act_m, act_n, act_d, 3'b0, act_prediv}, 0);
    check("R1", "active src/mode", {act_src, act_mode}, 0);
    check("R1", "select", 32'(src_sel_oh), 1);

    // R7 root enable path, bit31 read-only
    wr(A_CMD, 32'h8000_0002);
    rd(A_CMD, r); check("R7", "cmd before low", r, 32'h8000_0002);
    check("R7", "gate held", 32'(root_gate_en), 0);
    root_clk_low = 1'b1; tick(); root_clk_low = 1'b0;
    check("R7", "gate on", 32'(root_gate_en), 1);
    rd(A_CMD, r); check("R7", "off flag clear", r, 32'h0000_0002);

    o_pd = 0; o_src = 0; o_md = 0; o_m = 0; o_n = 0; o_d = 0;
    for (int s = 0; s < 8; s++) begin
      int pd, md, m, n, d;
      logic [NUM_SRC-1:0] old_oh, exp1;
      pd = (s * 7 + 3) & 31; md = s & 3;
      m = (s * 29 + 5) & 255; n = (s * 13 + 200) & 255; d = (s * 41 + 7) & 255;
      exp_cfg = (md << 12) | (s << 8) | pd;
      wr(A_CFG, exp_cfg | 32'hF000_00E0);
      wr(A_M, 32'hFFFF_FF00 | m);
      wr(A_N, n);
      wr(A_D, d);
      rd(A_CMD, r); check("R3", "dirty all", r, 32'h0000_00F2);
      rd(A_CFG, r); check("R2", "cfg readback", r, exp_cfg);
      rd(A_M, r); check("R2", "M readback", r, m);
      rd(A_N, r); check("R2", "N readback", r, n);
      rd(A_D, r); check("R2", "D readback", r, d);
      check("R8", "active held", {act_m, act_n, act_d, 3'b0, act_prediv},
            {8'(o_m), 8'(o_n), 8'(o_d), 3'b0, 5'(o_pd)});
      wr(A_CMD, 32'h3);
      rd(A_CMD, r); check("R4", "request set", r, 32'h0000_00F3);
      wr(A_CMD, 32'h2);
      rd(A_CMD, r); check("R4", "zero keeps request", r, 32'h0000_00F3);
      tick();
      check("R5", "held while clk high", {act_src, act_mode, act_m}, {3'(o_src), 2'(o_md), 8'(o_m)});
      old_oh = src_sel_oh;
      root_clk_low = 1'b1; tick(); root_clk_low = 1'b0;
      check("R5", "active cfg", {act_src, act_mode, 3'b0, act_prediv}, {3'(s), 2'(md), 3'b0, 5'(pd)});
      check("R5", "active MND", {act_m, act_n, act_d}, {8'(m), 8'(n), 8'(d)});
      rd(A_CMD, r); check("R10", "request and dirty cleared", r, 32'h0000_0002);
      check("R9", "select before move", 32'(src_sel_oh), 32'(old_oh));
      tick();
      exp1 = (old_oh != 0 && old_oh != oh(s)) ? '0 : oh(s);
      check("R9", "select gap", 32'(src_sel_oh), 32'(exp1));
      tick();
      check("R9", "select final", 32'(src_sel_oh), 32'(oh(s)));
      o_pd = pd; o_src = s; o_md = md; o_m = m; o_n = n; o_d = d;
    end

    // R3 single dirty flag
    wr(A_N, 32'h11);
    rd(A_CMD, r); check("R3", "dirty N only", r, 32'h0000_0022);
    o_n = 32'h11;

    // R6 write in commit cycle
    wr(A_CMD, 32'h3);
    root_clk_low = 1'b1; bus_we = 1'b1; bus_addr = A_M; bus_wdata = 32'hAB;
    tick();
    bus_we = 1'b0; root_clk_low = 1'b0;
    check("R6", "active M old", 32'(act_m), 32'(o_m));
    check("R6", "active N new", 32'(act_n), 32'h11);
    rd(A_M, r); check("R6", "shadow M new", r, 32'hAB);
    rd(A_CMD, r); check("R6", "dirty M stays", r, 32'h0000_0042);
    wr(A_CMD, 32'h3);
    root_clk_low = 1'b1; bus_we = 1'b1; bus_addr = A_CMD; bus_wdata = 32'h3;
    tick();
    bus_we = 1'b0;
    check("R6", "M committed", 32'(act_m), 32'hAB);
    rd(A_CMD, r); check("R6", "re-request pending", r, 32'h0000_0003);
    tick(); root_clk_low = 1'b0;
    rd(A_CMD, r); check("R10", "request done", r, 32'h0000_0002);

    // R2 unmapped and misaligned accesses
    wr(5'h14, 32'hFFFF_FFFF);
    wr(5'h09, 32'h0000_0055);
    rd(5'h14, r); check("R2", "unmapped read", r, 0);
    rd(5'h09, r); check("R2", "misaligned read", r, 0);
    rd(A_M, r); check("R2", "M untouched", r, 32'hAB);
    rd(A_CMD, r); check("R2", "no dirty from stray", r, 32'h0000_0002);

    // R7 disable path
    wr(A_CMD, 32'h0);
    check("R7", "gate held on", 32'(root_gate_en), 1);
    root_clk_low = 1'b1; tick(); root_clk_low = 1'b0;
    check("R7", "gate off", 32'(root_gate_en), 0);
    rd(A_CMD, r); check("R7", "off flag set", r, 32'h8000_0000);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule